// File: doc/BRIEF.md
# Clocked Controller for an Asynchronous 128K x 8 Static RAM

This block connects a clocked system to an external asynchronous static RAM of 128K words by 8 bits. The user side presents one request at a time: a valid strobe, a write flag, a 17-bit address and a byte of write data. The block accepts the request only while it is idle. It then runs one complete memory access and signals the end of that access with a single-cycle done pulse. For a read, the byte that comes back appears alongside the done pulse.

On the memory side the block drives the address and two chip selects of opposite polarity: an active-low select and an active-high select. It also drives an active-low output enable, an active-low write enable, and a byte-wide data bus split into separate out, in and drive-enable signals. All memory pins come straight from flops, so they change only at clock edges. Each strobe width is a whole number of clock cycles. That number is derived from a nanosecond timing parameter and the clock-period parameter by rounding up, with a floor of one cycle.

Reads are controlled by the output enable. Writes are controlled by the write enable, and output enable stays high throughout a write. The data bus is driven only while write enable is low. Between accesses the memory is deselected, which puts it in standby.

Top module: `sram_port_ctrl`

## Requirements
- R1: After reset and whenever the controller is idle, `reqReady` is 1 and the memory is deselected: `memCe1N`=1, `memCe2`=0, `memOeN`=1, `memWeN`=1 and `memDoe`=0.
- R2: A request is taken only in a cycle where `reqValid` and `reqReady` are both 1. A request held while the controller is busy does not change the access in progress. It is taken only once the controller is idle again.
- R3: A read holds the memory selected (`memCe1N`=0, `memCe2`=1), `memOeN`=0 and `memWeN`=1, with the address unchanged, for RD cycles. RD is the largest of ceil(55/P), ceil(25/P) and ceil(55/P), where P is the clock period in ns. This gives 3 cycles at P=20.
- R4: The byte on `memDin` is captured at the clock edge that closes the read window. That same edge sets `rspDone` to 1 for exactly one cycle, so done is high in the cycle after edge k+RD, where edge k is the acceptance edge. `rspRData` then holds this byte until the next read completes.
- R5: A write holds `memWeN`=0 for WP cycles with `memOeN`=1 throughout. WP is the largest of ceil(40/P), ceil(50/P) and ceil(25/P), which gives 3 cycles at P=20. The request's byte sits on `memDout` and `memDoe`=1 exactly while `memWeN` is 0.
- R6: When `memWeN` returns high, the memory stays selected with the bus released for REC cycles. REC is the larger of 1 and ceil(55/P)-WP, which gives 1 cycle at P=20. `rspDone` pulses at the end of those cycles, which is 4 cycles after acceptance at P=20.
- R7: `memDoe` is never 1 while `memOeN` is 0.
- R8: A request that is present in the cycle where `rspDone` is 1 is accepted in that same cycle.
- R9: Data written to an address is returned by any later read of that address until another write to it. This includes a read accepted directly after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 17 | Word address of the request |
| reqWData | input | 8 | Byte to write |
| reqReady | output | 1 | Controller idle; request can be accepted |
| rspDone | output | 1 | One-cycle pulse at the end of every access |
| rspRData | output | 8 | Byte from the last completed read |
| memAddr | output | 17 | Memory address pins |
| memCe1N | output | 1 | Active-low chip select |
| memCe2 | output | 1 | Active-high chip select |
| memOeN | output | 1 | Active-low output enable |
| memWeN | output | 1 | Active-low write enable |
| memDout | output | 8 | Byte driven onto the memory data bus |
| memDin | input | 8 | Byte sampled from the memory data bus |
| memDoe | output | 1 | Drive enable for the memory data bus |

## Verification
The completion of one access and the acceptance of the next can fall in the same cycle. In that cycle the done pulse is high and the controller is already ready again. The bench provokes this by keeping a queue of requests with `reqValid` held high across whole accesses, so that the next request is waiting when done rises. A behavioural model predicts `reqReady`, `rspDone` and `rspRData` for every cycle, and the outputs are compared with it on each clock. A memory model in the bench returns unknown data until the address has been stable for 55 ns. It also commits a byte only on the rising edge of write enable, so a read window or write pulse that is too short, or a turnaround that collides with the next access, appears as a data or timing mismatch.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WPULSE,
    ST_WRECOV
  } state_e;

  // Strobes from control to datapath; pin fields give the next pin state, active high.
  typedef struct packed {
    logic load;     // latch address and write byte
    logic capture;  // sample the memory bus into the read register
    logic done;     // completion pulse for the next cycle
    logic sel;      // memory selected
    logic oe;       // output enable asserted
    logic we;       // write enable asserted
    logic drive;    // controller drives the data bus
  } strobe_t;

  // Whole cycles covering a time in ns, at least one.
  function automatic int cycFor(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC  = 3,
  parameter int WP_CYC  = 3,
  parameter int REC_CYC = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output strobe_t stb
);

  localparam int CNT_W = $clog2(maxOf(maxOf(RD_CYC, WP_CYC), REC_CYC) + 1);
  localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LAST  = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LAST = CNT_W'(REC_CYC - 1);

  state_e           state, nxtState;
  logic [CNT_W-1:0] cnt, nxtCnt;

  assign reqReady = (state == ST_IDLE);

  always_comb begin
    stb      = '0;
    nxtState = state;
    nxtCnt   = cnt;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          stb.load = 1'b1;
          stb.sel  = 1'b1;
          nxtCnt   = '0;
          if (reqWrite) begin
            nxtState  = ST_WPULSE;
            stb.we    = 1'b1;
            stb.drive = 1'b1;
          end else begin
            nxtState = ST_READ;
            stb.oe   = 1'b1;
          end
        end
      end
      ST_READ: begin
        if (cnt == RD_LAST) begin
          stb.capture = 1'b1;
          stb.done    = 1'b1;
          nxtState    = ST_IDLE;
        end else begin
          nxtCnt  = cnt + 1'b1;
          stb.sel = 1'b1;
          stb.oe  = 1'b1;
        end
      end
      ST_WPULSE: begin
        stb.sel = 1'b1;
        if (cnt == WP_LAST) begin
          nxtCnt   = '0;
          nxtState = ST_WRECOV;
        end else begin
          nxtCnt    = cnt + 1'b1;
          stb.we    = 1'b1;
          stb.drive = 1'b1;
        end
      end
      ST_WRECOV: begin
        if (cnt == REC_LAST) begin
          stb.done = 1'b1;
          nxtState = ST_IDLE;
        end else begin
          nxtCnt  = cnt + 1'b1;
          stb.sel = 1'b1;
        end
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nxtState;
      cnt   <= nxtCnt;
    end
  end

  // R3
  read_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READ && cnt != RD_LAST) |=> (state == ST_READ));

  // R5
  wpulse_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WPULSE && cnt != WP_LAST) |=> (state == ST_WPULSE));

endmodule

// File: rtl/sram_ctrl_dp.sv
module sram_ctrl_dp
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWData,
  input  logic [DATA_W-1:0] memDin,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoe,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspRData
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr  <= '0;
      memDout  <= '0;
      memCe1N  <= 1'b1;
      memCe2   <= 1'b0;
      memOeN   <= 1'b1;
      memWeN   <= 1'b1;
      memDoe   <= 1'b0;
      rspDone  <= 1'b0;
      rspRData <= '0;
    end else begin
      if (stb.load) begin
        memAddr <= reqAddr;
        memDout <= reqWData;
      end
      memCe1N <= ~stb.sel;
      memCe2  <= stb.sel;
      memOeN  <= ~stb.oe;
      memWeN  <= ~stb.we;
      memDoe  <= stb.drive;
      rspDone <= stb.done;
      if (stb.capture) rspRData <= memDin;
    end
  end

  // R7
  no_bus_clash_chk: assert property (@(posedge clk) disable iff (!rstN)
    memDoe |-> memOeN);

  // R5
  we_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (memDoe && memOeN && !memCe1N && memCe2));

  // R6
  bus_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (!memDoe && !memCe1N));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int CLK_NS = 20,
  parameter int T_RC   = 55,
  parameter int T_AA   = 55,
  parameter int T_OE   = 25,
  parameter int T_WP   = 40,
  parameter int T_AW   = 50,
  parameter int T_DW   = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWData,
  output logic              reqReady,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspRData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDout,
  input  logic [DATA_W-1:0] memDin,
  output logic              memDoe
);

  localparam int RD_CYC  = maxOf(maxOf(cycFor(T_AA, CLK_NS), cycFor(T_OE, CLK_NS)),
                                 cycFor(T_RC, CLK_NS));
  localparam int WP_CYC  = maxOf(maxOf(cycFor(T_WP, CLK_NS), cycFor(T_AW, CLK_NS)),
                                 cycFor(T_DW, CLK_NS));
  localparam int REC_CYC = maxOf(1, cycFor(T_RC, CLK_NS) - WP_CYC);

  strobe_t stb;

  sram_ctrl_fsm #(
    .RD_CYC (RD_CYC),
    .WP_CYC (WP_CYC),
    .REC_CYC(REC_CYC)
  ) uCtl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .stb     (stb)
  );

  sram_ctrl_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .reqAddr (reqAddr),
    .reqWData(reqWData),
    .memDin  (memDin),
    .memAddr (memAddr),
    .memCe1N (memCe1N),
    .memCe2  (memCe2),
    .memOeN  (memOeN),
    .memWeN  (memWeN),
    .memDout (memDout),
    .memDoe  (memDoe),
    .rspDone (rspDone),
    .rspRData(rspRData)
  );

  // R1
  idle_deselect_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCe1N && !memCe2 && memOeN && memWeN && !memDoe));

  // R2
  busy_addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!reqReady && $past(!reqReady)) |-> $stable(memAddr));

  // R8
  done_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |-> reqReady);

endmodule

// File: tb/sim_sram_port_ctrl.sv
`timescale 1ns/1ps
module sim_sram_port_ctrl;

  localparam int CLK_NS = 20;
  localparam int RD_LEN = 3;   // ceil(55/20)
  localparam int WP_LEN = 3;   // ceil(50/20)
  localparam int WR_LEN = 4;   // pulse plus one release cycle
  localparam int LIMIT  = 100000;

  typedef struct {
    bit          v;
    bit          w;
    logic [16:0] a;
    logic [7:0]  d;
  } op_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [16:0] reqAddr = '0;
  logic [7:0]  reqWData = '0;
  logic reqReady, rspDone, memCe1N, memCe2, memOeN, memWeN, memDoe;
  logic [7:0]  rspRData, memDout;
  logic [7:0]  memDin = 8'hzz;
  logic [16:0] memAddr;

  always #(CLK_NS/2) clk = ~clk;

  sram_port_ctrl u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWData(reqWData), .reqReady(reqReady),
    .rspDone(rspDone), .rspRData(rspRData), .memAddr(memAddr),
    .memCe1N(memCe1N), .memCe2(memCe2), .memOeN(memOeN), .memWeN(memWeN),
    .memDout(memDout), .memDin(memDin), .memDoe(memDoe)
  );

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural memory and reference model.
  logic [7:0] mem    [int];
  logic [7:0] refMem [int];
  op_t        ops[$];

  function automatic logic [7:0] peek(input int a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  function automatic logic [7:0] peekRef(input int a);
    return refMem.exists(a) ? refMem[a] : 8'h00;
  endfunction

  int          busy = 0;
  bit          expDone = 0, expRead = 0, runModel = 0;
  logic [7:0]  expData = '0, lastRd = '0, wrLatch = '0;
  int          age = 0, weLow = 0;
  bit          prevAct = 0;
  logic        prevWeN = 1'b1;
  logic [16:0] prevAddr = '0;

  always @(negedge clk) begin
    if (runModel) begin
      bit act, accept;
      // memory model: write commit and pulse width
      if (!memWeN) begin
        weLow++;
        // R5 bus driven while write enable is low
        check(memDoe === 1'b1 && memOeN === 1'b1, "R5 drive during WE low",
              {memDoe, memOeN}, 2'b11);
        wrLatch = memDout;
      end
      if (prevWeN === 1'b0 && memWeN === 1'b1) begin
        check(weLow >= WP_LEN, "R5 WE pulse width", weLow, WP_LEN);
        // R6 still selected, bus released after WE rises
        check(memCe1N === 1'b0 && memDoe === 1'b0, "R6 release cycle",
              {memCe1N, memDoe}, 2'b00);
        mem[int'(memAddr)] = wrLatch;
        weLow = 0;
      end
      prevWeN = memWeN;
      // R7
      check(!(memDoe === 1'b1 && memOeN === 1'b0), "R7 bus clash", {memDoe, memOeN}, 2'b01);
      // memory model: read data valid only after 55 ns of stable access
      act = (memCe1N === 1'b0) && (memCe2 === 1'b1) && (memOeN === 1'b0) && (memWeN === 1'b1);
      if (act) age = (prevAct && memAddr == prevAddr) ? age + 1 : 1;
      else age = 0;
      prevAct  = act;
      prevAddr = memAddr;
      if (!act) memDin = 8'hzz;
      else if (age * CLK_NS >= 55) memDin = peek(int'(memAddr));
      else memDin = 8'hxx;

      // compare outputs with the reference
      check(reqReady === (busy == 0), "R2 R8 ready", reqReady, busy == 0);
      check(rspDone === expDone, "R4 R6 done", rspDone, expDone);
      if (expDone && expRead) lastRd = expData;
      check(rspRData === lastRd, "R3 R4 R9 read data", rspRData, lastRd);
      if (busy == 0)
        check({memCe1N, memCe2, memOeN, memWeN, memDoe} === 5'b10110, "R1 idle pins",
              {memCe1N, memCe2, memOeN, memWeN, memDoe}, 5'b10110);

      // drive next request
      if (ops.size() > 0) begin
        reqValid = ops[0].v; reqWrite = ops[0].w;
        reqAddr  = ops[0].a; reqWData = ops[0].d;
      end else begin
        reqValid = 1'b0;
      end
      accept = reqValid && (busy == 0);
      if (ops.size() > 0 && (accept || !ops[0].v)) void'(ops.pop_front());

      // advance reference across the next edge
      expDone = 0;
      if (busy > 0) begin
        busy--;
        if (busy == 0) expDone = 1;
      end else if (accept) begin
        busy    = reqWrite ? WR_LEN : RD_LEN;
        expRead = !reqWrite;
        expData = peekRef(int'(reqAddr));
        if (reqWrite) refMem[int'(reqAddr)] = reqWData;
      end
    end
  end

  function automatic op_t mk(input bit v, input bit w, input logic [16:0] a,
                             input logic [7:0] d);
    op_t o;
    o.v = v; o.w = w; o.a = a; o.d = d;
    return o;
  endfunction

  initial begin
    int cyc = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(reqReady === 1'b1 && rspDone === 1'b0, "R1 reset ready/done",
          {reqReady, rspDone}, 2'b10);
    check({memCe1N, memCe2, memOeN, memWeN, memDoe} === 5'b10110, "R1 reset pins",
          {memCe1N, memCe2, memOeN, memWeN, memDoe}, 5'b10110);
    // directed: edges of address space, read of unwritten word, back-to-back R8 R9
    ops.push_back(mk(1, 0, 17'h00005, 8'h00));
    ops.push_back(mk(1, 1, 17'h00000, 8'hA5));
    ops.push_back(mk(1, 0, 17'h00000, 8'h00));
    ops.push_back(mk(1, 1, 17'h1FFFF, 8'hFF));
    ops.push_back(mk(1, 1, 17'h10000, 8'h00));
    ops.push_back(mk(1, 0, 17'h1FFFF, 8'h00));
    ops.push_back(mk(0, 0, 17'h0, 8'h0));
    ops.push_back(mk(1, 0, 17'h10000, 8'h00));
    ops.push_back(mk(1, 1, 17'h00000, 8'h3C));
    ops.push_back(mk(0, 0, 17'h0, 8'h0));
    ops.push_back(mk(0, 0, 17'h0, 8'h0));
    ops.push_back(mk(1, 0, 17'h00000, 8'h00));
    ops.push_back(mk(1, 0, 17'h00000, 8'h00));
    for (int i = 0; i < 400; i++) begin
      logic [16:0] a;
      a = 17'($urandom % 16);
      if ($urandom % 4 == 0) a = a | 17'h1FFF0;
      ops.push_back(mk(($urandom % 5) != 0, ($urandom % 2) == 1, a, 8'($urandom)));
    end
    rstN = 1'b1;
    runModel = 1;
    while ((ops.size() > 0 || busy > 0 || expDone) && cyc < LIMIT) begin
      @(negedge clk);
      cyc++;
    end
    repeat (4) @(negedge clk);
    if (cyc >= LIMIT) check(1'b0, "watchdog", cyc, LIMIT);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule